// File: doc/BRIEF.md
# Digital PLL Lock Monitor

This block watches a reference clock and the divided feedback clock of a phase-locked loop, and drives a single lock status flag. Both clocks are treated as asynchronous levels. They are sampled by a fast system clock through synchronizer chains, and each rising edge becomes a one-cycle pulse. How loss of lock is judged depends on the active multiplication factor. When the factor is above four, the block keeps a signed reference-minus-feedback edge difference and declares a slip if that difference stays non-zero for a whole reference period. When the factor is four or less, the phase error is too small to resolve in the digital domain. An external skew-fault flag, produced synchronously to the system clock by an analog comparator, decides loss instead.

Software writes the divide and multiply factors through separate strobes. A divide write takes effect on the next edge. A multiply write is staged for one further edge, so the new divide factor is always in use before the new multiply factor. Every multiply write also drops lock and restarts qualification. After a loss, lock returns only once a programmable number of back-to-back clean reference periods has been seen.

Top module: `pll_lock_monitor`

## Requirements
- R1: In reset and in the first cycle after it, `locked` is 0, `div_active` is 0 and `mul_active` is 8.
- R2: A cycle with `div_wr` high makes `div_active` equal `div_val` from the next clock edge.
- R3: A cycle with `mul_wr` high loads `mul_val` into `mul_active` at the second following edge. At that same edge `locked` goes to 0, even when the value written equals the current one.
- R4: When `div_wr` and `mul_wr` are high in the same cycle, `div_active` changes one edge before `mul_active` does.
- R5: With `mul_active` greater than 4, a reference rising edge that ends a period in which the edge difference was non-zero in every cycle is a slip, and `locked` is 0 after the next edge. A missing feedback edge is one such case.
- R6: With `mul_active` of 4 or less, a cycle with `skew_fault` high makes `locked` 0 after the next edge, and the edge difference plays no part, so a stopped feedback clock leaves `locked` at 1.
- R7: With `mul_active` greater than 4, `skew_fault` has no effect on `locked`.
- R8: After a loss or a restart, `locked` rises once `qual_len` consecutive reference periods have passed with no loss. A `qual_len` of 0 selects 16 periods.
- R9: The edge difference is held to the range -7 to +7 and is cleared on any loss. A feedback clock that runs faster than the reference therefore builds up a slip and drops lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Reference clock level, asynchronous |
| fb_clk_in | input | 1 | Divided feedback clock level, asynchronous |
| skew_fault | input | 1 | Phase-skew violation flag for low multiplication, synchronous to clk |
| qual_len | input | 8 | Clean reference periods needed to declare lock, 0 selects 16 |
| div_wr | input | 1 | Divide factor write strobe |
| div_val | input | 4 | Divide factor write data |
| mul_wr | input | 1 | Multiply factor write strobe |
| mul_val | input | 12 | Multiply factor write data |
| div_active | output | 4 | Divide factor in use |
| mul_active | output | 12 | Multiply factor in use, selects the detection mode |
| locked | output | 1 | Lock status |

## Verification
Most wrong internal states show up on `locked` within one or two reference periods. If the difference counter miscounts or forgets to clear, a slip appears in a loop that is running cleanly, or a missing edge goes unnoticed. If the qualification count is off, `locked` rises a period early or late. If the mode is decoded wrongly, either skew faults are obeyed in high-multiplication mode or a stopped feedback clock drops lock in low mode. Errors in the configuration pipeline show up on `div_active` and `mul_active` on the first or second edge after a write. For that reason the bench compares every output against its model on every cycle and does not wait for checkpoints alone.

// File: rtl/lm_pkg.sv
package lm_pkg;

    typedef enum logic {
        MODE_SKEW = 1'b0,
        MODE_SLIP = 1'b1
    } mode_e;

    typedef struct packed {
        logic ref_rise;
        logic fb_rise;
    } edge_pair_t;

    function automatic mode_e pick_mode(int unsigned mul, int unsigned low_max);
        return (mul > low_max) ? MODE_SLIP : MODE_SKEW;
    endfunction

    function automatic int unsigned qual_target(int unsigned len, int unsigned dflt);
        return (len == 0) ? dflt : len;
    endfunction

endpackage

// File: rtl/lm_edge_sync.sv
module lm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/lm_cfg_stage.sv
module lm_cfg_stage #(
    parameter int MUL_W     = 12,
    parameter int DIV_W     = 4,
    parameter int MUL_RESET = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    input  logic             mul_wr,
    input  logic [MUL_W-1:0] mul_val,
    output logic [DIV_W-1:0] div_active,
    output logic [MUL_W-1:0] mul_active,
    output logic             restart
);
    logic [MUL_W-1:0] mul_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_active <= '0;
            mul_active <= MUL_W'(MUL_RESET);
            mul_stage  <= '0;
            restart    <= 1'b0;
        end else begin
            if (div_wr)  div_active <= div_val;
            if (restart) mul_active <= mul_stage;
            if (mul_wr)  mul_stage  <= mul_val;
            restart <= mul_wr;
        end
    end

    assert_div_apply_R2: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> div_active == $past(div_val))
        else $error("divide factor not applied on next edge");

    assert_mul_apply_R3: assert property (@(posedge clk) disable iff (rst)
        mul_wr |=> ##1 mul_active == $past(mul_val, 2))
        else $error("multiply factor not applied on second edge");

    assert_div_first_R4: assert property (@(posedge clk) disable iff (rst)
        (div_wr && mul_wr && !restart) |=> mul_active == $past(mul_active))
        else $error("multiply factor changed together with divide factor");
endmodule

// File: rtl/lm_slip_det.sv
module lm_slip_det #(
    parameter int DIFF_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic slip
);
    localparam logic signed [DIFF_W-1:0] DMAX = {1'b0, {(DIFF_W-1){1'b1}}};
    localparam logic signed [DIFF_W-1:0] DMIN = -DMAX;

    logic signed [DIFF_W-1:0] diff, nxt;
    logic seen_zero;

    always_comb begin
        nxt = diff;
        if (ref_rise && !fb_rise && diff != DMAX)      nxt = diff + DIFF_W'(1);
        else if (fb_rise && !ref_rise && diff != DMIN) nxt = diff - DIFF_W'(1);
    end

    assign slip = ref_rise && !seen_zero && (diff != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            diff      <= '0;
            seen_zero <= 1'b1;
        end else begin
            diff      <= nxt;
            seen_zero <= ref_rise ? 1'b0 : (seen_zero | (diff == '0));
        end
    end

    assert_diff_range_R9: assert property (@(posedge clk) disable iff (rst)
        diff != -DMAX - DIFF_W'(1))
        else $error("difference counter wrapped");

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clear |=> !slip)
        else $error("slip reported right after clear");
endmodule

// File: rtl/lm_qualifier.sv
module lm_qualifier #(
    parameter int QUAL_W       = 8,
    parameter int DEFAULT_QUAL = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              loss,
    input  logic              tick,
    input  logic [QUAL_W-1:0] qual_len,
    output logic              locked
);
    import lm_pkg::*;

    logic [QUAL_W-1:0] cnt;
    int unsigned       tgt;

    assign tgt = qual_target(32'(qual_len), DEFAULT_QUAL);

    always_ff @(posedge clk) begin
        if (rst || restart || loss) begin
            locked <= 1'b0;
            cnt    <= '0;
        end else if (tick && !locked) begin
            if (32'(cnt) + 1 >= tgt) begin
                locked <= 1'b1;
                cnt    <= '0;
            end else begin
                cnt <= cnt + QUAL_W'(1);
            end
        end
    end

    assert_restart_unlock_R3: assert property (@(posedge clk) disable iff (rst)
        restart |=> !locked)
        else $error("lock held across multiply write");

    assert_loss_unlock_R5: assert property (@(posedge clk) disable iff (rst)
        loss |=> !locked)
        else $error("lock held after loss");

    assert_rise_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(tick))
        else $error("lock rose away from a reference edge");
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
    parameter int          MUL_W        = 12,
    parameter int          DIV_W        = 4,
    parameter int          QUAL_W       = 8,
    parameter int          DIFF_W       = 4,
    parameter int          SYNC_STAGES  = 2,
    parameter int          DEFAULT_QUAL = 16,
    parameter int          MUL_RESET    = 8,
    parameter int unsigned LOW_MUL_MAX  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_clk_in,
    input  logic              fb_clk_in,
    input  logic              skew_fault,
    input  logic [QUAL_W-1:0] qual_len,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              mul_wr,
    input  logic [MUL_W-1:0]  mul_val,
    output logic [DIV_W-1:0]  div_active,
    output logic [MUL_W-1:0]  mul_active,
    output logic              locked
);
    import lm_pkg::*;

    localparam int NCH = 2;

    logic [NCH-1:0] raw, rise;
    edge_pair_t     ev;
    mode_e          mode;
    logic           restart, slip, loss, clear;

    assign raw = {fb_clk_in, ref_clk_in};

    for (genvar g = 0; g < NCH; g++) begin : g_sync
        lm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw[g]),
            .rise(rise[g])
        );
    end

    assign ev = '{ref_rise: rise[0], fb_rise: rise[1]};

    lm_cfg_stage #(.MUL_W(MUL_W), .DIV_W(DIV_W), .MUL_RESET(MUL_RESET)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .div_wr    (div_wr),
        .div_val   (div_val),
        .mul_wr    (mul_wr),
        .mul_val   (mul_val),
        .div_active(div_active),
        .mul_active(mul_active),
        .restart   (restart)
    );

    assign mode  = pick_mode(32'(mul_active), LOW_MUL_MAX);
    assign loss  = (mode == MODE_SLIP) ? slip : skew_fault;
    assign clear = restart | loss;

    lm_slip_det #(.DIFF_W(DIFF_W)) u_slip (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .ref_rise(ev.ref_rise),
        .fb_rise (ev.fb_rise),
        .slip    (slip)
    );

    lm_qualifier #(.QUAL_W(QUAL_W), .DEFAULT_QUAL(DEFAULT_QUAL)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .loss    (loss),
        .tick    (ev.ref_rise),
        .qual_len(qual_len),
        .locked  (locked)
    );

    assert_skew_unlock_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SKEW && skew_fault) |=> !locked)
        else $error("skew fault ignored in low multiplication mode");

    assert_skew_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLIP && skew_fault && !slip && !restart && locked) |=> locked)
        else $error("skew fault acted in high multiplication mode");
endmodule

// File: tb/pll_lock_monitor_tb.sv
`timescale 1ns/1ps
module pll_lock_monitor_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_clk_in = 1'b0, fb_clk_in = 1'b0, skew_fault = 1'b0;
    logic [7:0]  qual_len = 8'd0;
    logic        div_wr = 1'b0, mul_wr = 1'b0;
    logic [3:0]  div_val = '0;
    logic [11:0] mul_val = '0;
    logic [3:0]  div_active;
    logic [11:0] mul_active;
    logic        locked;

    always #4 clk = ~clk;

    pll_lock_monitor u_dut (
        .clk(clk), .rst(rst), .ref_clk_in(ref_clk_in), .fb_clk_in(fb_clk_in),
        .skew_fault(skew_fault), .qual_len(qual_len), .div_wr(div_wr), .div_val(div_val),
        .mul_wr(mul_wr), .mul_val(mul_val), .div_active(div_active),
        .mul_active(mul_active), .locked(locked)
    );

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    done = 0, saw_loss = 0, model_on = 0;

    // clock generators
    int fb_per = 8;
    bit fb_stuck = 0;
    initial begin
        int rc = 0, fc = 3;
        forever begin
            @(negedge clk);
            ref_clk_in = (rc < 4);
            rc = (rc + 1) % 8;
            fb_clk_in = fb_stuck ? 1'b0 : (fc < fb_per / 2);
            fc = (fc + 1) % fb_per;
        end
    end

    // behavioural reference model
    bit rq[$], fq[$];
    int m_diff, m_q, m_div, m_mul, m_stage;
    bit m_seen, m_locked, m_pend;
    always @(posedge clk) begin
        if (rst) begin
            rq = '{0, 0, 0}; fq = '{0, 0, 0};
            m_diff = 0; m_seen = 1; m_q = 0; m_locked = 0;
            m_div = 0; m_mul = 8; m_stage = 0; m_pend = 0;
            model_on = 1;
        end else begin
            bit rp, fp, slip, loss, restart;
            int tgt, nd;
            rp = rq[1] && !rq[2];
            fp = fq[1] && !fq[2];
            rq.push_front(ref_clk_in); void'(rq.pop_back());
            fq.push_front(fb_clk_in);  void'(fq.pop_back());
            slip = rp && !m_seen && m_diff != 0;
            loss = (m_mul > 4) ? slip : skew_fault;
            restart = m_pend;
            tgt = (qual_len == 0) ? 16 : int'(qual_len);
            if (restart || loss) begin
                m_locked = 0; m_q = 0; m_diff = 0; m_seen = 1;
            end else begin
                nd = m_diff;
                if (rp && !fp && m_diff != 7) nd = m_diff + 1;
                else if (fp && !rp && m_diff != -7) nd = m_diff - 1;
                m_seen = rp ? 1'b0 : (m_seen || m_diff == 0);
                m_diff = nd;
                if (rp && !m_locked) begin
                    if (m_q + 1 >= tgt) begin m_locked = 1; m_q = 0; end
                    else m_q = m_q + 1;
                end
            end
            if (div_wr) m_div = int'(div_val);
            if (restart) m_mul = m_stage;
            if (mul_wr) m_stage = int'(mul_val);
            m_pend = mul_wr;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (model_on && !done) begin
            checks++;
            if (locked !== m_locked || int'(div_active) != m_div || int'(mul_active) != m_mul) begin
                errors++;
                $display("FAIL %s model: locked=%0b div=%0d mul=%0d expected locked=%0b div=%0d mul=%0d",
                         cur_req, locked, div_active, mul_active, m_locked, m_div, m_mul);
            end
            if (!rst && !locked) saw_loss = 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cycles(4);
        rst = 1'b0;
        cycles(1);
        // R1 reset state
        chk("R1 locked", locked, 0);
        chk("R1 div", div_active, 0);
        chk("R1 mul", mul_active, 8);

        // R8 default qualification of 16 periods
        cur_req = "R8";
        cycles(100);
        chk("R8 not yet locked", locked, 0);
        cycles(80);
        chk("R8 locked after 16 periods", locked, 1);

        // R5 missing feedback edge in high mode
        cur_req = "R5";
        fb_stuck = 1;
        cycles(24);
        chk("R5 slip drops lock", locked, 0);
        fb_stuck = 0;

        // R8 short qualification
        cur_req = "R8";
        qual_len = 8'd4;
        cycles(80);
        chk("R8 relock qual_len 4", locked, 1);

        // R9 faster feedback accumulates a slip
        cur_req = "R9";
        saw_loss = 0;
        fb_per = 7;
        cycles(400);
        chk("R9 drift detected", saw_loss, 1);
        fb_per = 8;
        cycles(120);
        chk("R9 relock after drift", locked, 1);

        // R2 divide write
        cur_req = "R2";
        div_val = 4'd5; div_wr = 1;
        cycles(1);
        div_wr = 0;
        chk("R2 div applied", div_active, 5);

        // R4 / R3 combined write
        cur_req = "R4";
        div_val = 4'd9; div_wr = 1; mul_val = 12'd3; mul_wr = 1;
        cycles(1);
        div_wr = 0; mul_wr = 0;
        chk("R4 div first", div_active, 9);
        chk("R4 mul not yet", mul_active, 8);
        cycles(1);
        cur_req = "R3";
        chk("R3 mul applied", mul_active, 3);
        chk("R3 lock cleared", locked, 0);

        // R6 low mode: slips ignored, skew fault acts
        cur_req = "R6";
        cycles(60);
        chk("R6 low mode locks", locked, 1);
        fb_stuck = 1;
        cycles(40);
        chk("R6 stopped feedback ignored", locked, 1);
        skew_fault = 1;
        cycles(1);
        skew_fault = 0;
        chk("R6 skew drops lock", locked, 0);
        fb_stuck = 0;

        // R3 same-value write still restarts
        cur_req = "R3";
        cycles(60);
        chk("R3 relocked", locked, 1);
        mul_val = 12'd3; mul_wr = 1;
        cycles(1);
        mul_wr = 0;
        cycles(1);
        chk("R3 same value clears lock", locked, 0);

        // R7 high mode ignores skew fault
        cur_req = "R7";
        mul_val = 12'd10; mul_wr = 1;
        cycles(1);
        mul_wr = 0;
        cycles(80);
        chk("R7 high mode locked", locked, 1);
        skew_fault = 1;
        cycles(5);
        skew_fault = 0;
        chk("R7 skew ignored", locked, 1);
        chk("R7 mul value", mul_active, 10);

        cycles(4);
        finish_run();
    end
endmodule